// File: doc/BRIEF.md
# Deflection Control Register Bank with Retrace-Committed Updates

This block is the serial control port of a display deflection controller. A host reaches it over a two-wire I2C bus. A write transaction names one of sixteen control registers through a subaddress byte and then streams data bytes into consecutive registers. A read transaction skips the subaddress and returns a status byte straight away. The status byte carries lock flags, the protection latch, the detected sync polarities and the detected sync type.

Each control register is held twice. Bus writes land only in a staging copy. The live copy, which drives the analog geometry circuits, takes every staged value together when the vertical retrace strobe arrives. A picture therefore never changes shape in the middle of a frame. The one exception is the protection-latch release request in register 0x00. It produces a clear pulse as soon as its data byte is received and does not wait for retrace.

The bus lines are brought into the system clock domain by two-flop synchronizers. The block oversamples SCL and SDA, so the system clock must be much faster than SCL. START and STOP conditions are found from SDA edges while SCL is high.

Top module: `defl_ctrl_regbank`

## Requirements
- R1: After reset, every staging and live register holds its default, by subaddress: 00=0x00, 01=0x40, 02=0x00, 03=0x00, 04=0x40, 05=0xC0, 06=0x40, 07=0x20, 08=0x20, 09=0xA0, 0A=0x40, 0B=0xC0, 0C=0x00, 0D=0xA0, 0E=0xA0, 0F=0x20. SDA is not driven.
- R2: The slave acknowledges the address byte 0x8C (write) and 0x8D (read). Any other address byte is not acknowledged, and the rest of that transaction changes no register.
- R3: A subaddress byte of 0x00 to 0x0F is acknowledged. A larger value is not acknowledged, and the data bytes that follow it are neither acknowledged nor stored.
- R4: Each acknowledged data byte is stored in the staging register that the current subaddress selects. The subaddress then advances by one, so one transaction fills consecutive registers.
- R5: The live outputs (register n on bits 8n+7..8n of the live bus) do not change while the retrace strobe is low. On the clock edge where the strobe is sampled high, every live register takes its staging value.
- R6: When auto-increment has passed subaddress 0x0F, later data bytes in the same transaction are not acknowledged and are not stored. There is no wrap to 0x00.
- R7: After the read address is acknowledged, the slave sends the status byte, MSB first. The bits, from bit 7 down to bit 0, are: horizontal lock, vertical lock, X-ray latch, horizontal polarity, vertical polarity, extracted-vertical-sync detected, separate-sync detected, and 0.
- R8: After each status byte, a master ACK makes the slave sample the status inputs again and send a new byte. A master NACK makes the slave release SDA until the next START.
- R9: A write to subaddress 0x00 with bit 6 set produces exactly one single-cycle clear pulse, before any retrace. A write to 0x00 with bit 6 clear produces no pulse. Bit 7 of register 0x00 is the horizontal drive enable and is committed like any other bit.
- R10: A START, including a repeated START, always restarts address reception. A STOP ends any transaction, so a write cut short after its subaddress leaves the registers unchanged and the next transaction works normally.
- R11: The slave changes its SDA drive only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line |
| sda_i | input | 1 | Bus data line, as resolved on the wire |
| sda_oe_o | output | 1 | Pull SDA low when 1 (open drain) |
| vretrace_i | input | 1 | Vertical retrace strobe, synchronous to clk |
| hlock_i | input | 1 | Horizontal PLL locked |
| vlock_i | input | 1 | Vertical section locked |
| xray_latched_i | input | 1 | Protection latch is set |
| hpol_i | input | 1 | Detected horizontal sync polarity |
| vpol_i | input | 1 | Detected vertical sync polarity |
| vext_det_i | input | 1 | Extracted vertical sync detected |
| sep_det_i | input | 1 | Separate H/V sync detected |
| live_regs_o | output | 128 | Live control registers, register n on bits 8n+7..8n |
| xray_clr_o | output | 1 | Single-cycle protection latch release pulse |

## Verification
Each bus input reaches the engine through two synchronizer flops and one edge-detect flop. The engine then reacts one edge later. This puts slave SDA changes about four clocks after an SCL edge. The bench holds every SCL phase for twenty clocks and samples SDA ten clocks into the high phase, well past that latency.

Staging writes happen on the eighth data rise, and a commit is visible one edge after the strobe. The bench therefore reads the live bus only after a STOP, pulses the strobe for one clock, and samples at the next falling edge. The clear pulse is counted over the whole transaction. Status inputs are changed before the master acknowledge, so they are synchronized well before the next byte is loaded.

// File: rtl/defl_regbank_pkg.sv
package defl_regbank_pkg;

    localparam int REG_W    = 8;
    localparam int NUM_REGS = 16;
    localparam int XCLR_BIT = 6;

    typedef logic [REG_W-1:0] byte_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_SUB,
        ST_WDATA,
        ST_ACK,
        ST_TX,
        ST_RACK,
        ST_WAIT
    } slv_state_e;

    typedef struct packed {
        logic  valid;
        byte_t idx;
        byte_t data;
    } wr_req_t;

    typedef struct packed {
        logic hlock;
        logic vlock;
        logic xray;
        logic hpol;
        logic vpol;
        logic vext;
        logic sepdet;
        logic spare;
    } status_t;

    function automatic byte_t reg_default(input int idx);
        byte_t v;
        case (idx)
            1, 4, 6, 10:  v = 8'h40;
            5, 11:        v = 8'hC0;
            7, 8, 15:     v = 8'h20;
            9, 13, 14:    v = 8'hA0;
            default:      v = 8'h00;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic scl_raw,
    input  logic sda_raw,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [STAGES-1:0] scl_pipe, sda_pipe;
    logic              scl_q, sda_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_q    <= 1'b1;
            sda_q    <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[STAGES-2:0], scl_raw};
            sda_pipe <= {sda_pipe[STAGES-2:0], sda_raw};
            scl_q    <= scl_pipe[STAGES-1];
            sda_q    <= sda_pipe[STAGES-1];
        end
    end

    assign scl_s     = scl_pipe[STAGES-1];
    assign sda_s     = sda_pipe[STAGES-1];
    assign scl_rise  = scl_s & ~scl_q;
    assign scl_fall  = ~scl_s & scl_q;
    assign start_det = scl_s & scl_q & sda_q & ~sda_s;
    assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;

endmodule

// File: rtl/status_sync.sv
module status_sync #(
    parameter int WIDTH  = 7,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d_in,
    output logic [WIDTH-1:0] d_out
);
    logic [WIDTH-1:0] pipe_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst)
                    pipe_q[s] <= '0;
                else if (s == 0)
                    pipe_q[s] <= d_in;
                else
                    pipe_q[s] <= pipe_q[(s == 0) ? 0 : s-1];
            end
        end
    endgenerate

    assign d_out = pipe_q[STAGES-1];

endmodule

// File: rtl/i2c_slave_engine.sv
module i2c_slave_engine
    import defl_regbank_pkg::*;
#(
    parameter logic [6:0] SLAVE_ADDR = 7'h46,
    parameter int         NUM_REGS_P = NUM_REGS
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_s,
    input  logic    sda_s,
    input  logic    scl_rise,
    input  logic    scl_fall,
    input  logic    start_det,
    input  logic    stop_det,
    input  byte_t   status_byte,
    output logic    sda_oe,
    output wr_req_t wr
);
    localparam byte_t LAST_SUB = byte_t'(NUM_REGS_P - 1);

    slv_state_e state_q, after_q;
    byte_t      sh_q, tx_q, ptr_q;
    logic [2:0] bitcnt_q;
    logic       full_q, ack_q, ptr_ok_q, mack_q;
    byte_t      rx_byte;

    assign rx_byte = {sh_q[6:0], sda_s};

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_IDLE;
            after_q  <= ST_IDLE;
            sh_q     <= '0;
            tx_q     <= '0;
            ptr_q    <= '0;
            bitcnt_q <= '0;
            full_q   <= 1'b0;
            ack_q    <= 1'b0;
            ptr_ok_q <= 1'b0;
            mack_q   <= 1'b0;
            sda_oe   <= 1'b0;
            wr       <= '0;
        end else begin
            wr.valid <= 1'b0;
            if (start_det) begin
                state_q  <= ST_ADDR;
                bitcnt_q <= '0;
                full_q   <= 1'b0;
                ptr_ok_q <= 1'b0;
                sda_oe   <= 1'b0;
            end else if (stop_det) begin
                state_q  <= ST_IDLE;
                full_q   <= 1'b0;
                ptr_ok_q <= 1'b0;
                sda_oe   <= 1'b0;
            end else begin
                case (state_q)
                    ST_ADDR, ST_SUB, ST_WDATA: begin
                        if (scl_rise && !full_q) begin
                            sh_q     <= rx_byte;
                            bitcnt_q <= bitcnt_q + 3'd1;
                            if (bitcnt_q == 3'd7) begin
                                full_q <= 1'b1;
                                if (state_q == ST_ADDR) begin
                                    ack_q   <= (rx_byte[7:1] == SLAVE_ADDR);
                                    after_q <= (rx_byte[7:1] != SLAVE_ADDR) ? ST_WAIT :
                                               (rx_byte[0] ? ST_TX : ST_SUB);
                                end else if (state_q == ST_SUB) begin
                                    if (rx_byte <= LAST_SUB) begin
                                        ack_q    <= 1'b1;
                                        ptr_q    <= rx_byte;
                                        ptr_ok_q <= 1'b1;
                                        after_q  <= ST_WDATA;
                                    end else begin
                                        ack_q   <= 1'b0;
                                        after_q <= ST_WAIT;
                                    end
                                end else begin
                                    if (ptr_ok_q) begin
                                        ack_q    <= 1'b1;
                                        wr.valid <= 1'b1;
                                        wr.idx   <= ptr_q;
                                        wr.data  <= rx_byte;
                                        ptr_q    <= ptr_q + 8'd1;
                                        if (ptr_q == LAST_SUB)
                                            ptr_ok_q <= 1'b0;
                                        after_q  <= ST_WDATA;
                                    end else begin
                                        ack_q   <= 1'b0;
                                        after_q <= ST_WAIT;
                                    end
                                end
                            end
                        end
                        if (scl_fall && full_q) begin
                            full_q  <= 1'b0;
                            sda_oe  <= ack_q;
                            state_q <= ST_ACK;
                        end
                    end
                    ST_ACK: begin
                        if (scl_fall) begin
                            bitcnt_q <= '0;
                            state_q  <= after_q;
                            if (after_q == ST_TX) begin
                                tx_q   <= status_byte;
                                sda_oe <= ~status_byte[7];
                            end else begin
                                sda_oe <= 1'b0;
                            end
                        end
                    end
                    ST_TX: begin
                        if (scl_fall) begin
                            if (bitcnt_q == 3'd7) begin
                                sda_oe   <= 1'b0;
                                bitcnt_q <= '0;
                                state_q  <= ST_RACK;
                            end else begin
                                tx_q     <= {tx_q[6:0], 1'b0};
                                sda_oe   <= ~tx_q[6];
                                bitcnt_q <= bitcnt_q + 3'd1;
                            end
                        end
                    end
                    ST_RACK: begin
                        if (scl_rise)
                            mack_q <= ~sda_s;
                        if (scl_fall) begin
                            if (mack_q) begin
                                tx_q    <= status_byte;
                                sda_oe  <= ~status_byte[7];
                                state_q <= ST_TX;
                            end else begin
                                state_q <= ST_WAIT;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // R11: drive level moves only while the bus clock is low
    assert_sda_scl_low_R11: assert property (@(posedge clk) disable iff (rst)
        !$stable(sda_oe) |-> !scl_s);

    // R10: a START always brings the engine back to address reception
    assert_start_restart_R10: assert property (@(posedge clk) disable iff (rst)
        start_det |=> (state_q == ST_ADDR) && !sda_oe);

    // R8: once the engine gives up a transaction it keeps SDA released
    assert_wait_released_R8: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_WAIT) |-> !sda_oe);

    // R3, R6: no data write may target a register beyond the last one
    assert_wr_in_range_R6: assert property (@(posedge clk) disable iff (rst)
        wr.valid |-> (wr.idx <= LAST_SUB));

endmodule

// File: rtl/ctrl_reg_file.sv
module ctrl_reg_file
    import defl_regbank_pkg::*;
#(
    parameter int NUM_REGS_P = NUM_REGS,
    parameter int CLR_BIT    = XCLR_BIT
) (
    input  logic                          clk,
    input  logic                          rst,
    input  wr_req_t                       wr,
    input  logic                          commit_i,
    output logic [NUM_REGS_P*REG_W-1:0]   live_flat_o,
    output logic                          xray_clr_o
);
    logic [NUM_REGS_P*REG_W-1:0] stage_flat;

    generate
        for (genvar g = 0; g < NUM_REGS_P; g++) begin : g_reg
            byte_t stage_q, live_q;
            always_ff @(posedge clk) begin
                if (rst) begin
                    stage_q <= reg_default(g);
                    live_q  <= reg_default(g);
                end else begin
                    if (wr.valid && (wr.idx == byte_t'(g)))
                        stage_q <= wr.data;
                    if (commit_i)
                        live_q <= stage_q;
                end
            end
            assign stage_flat[g*REG_W +: REG_W]  = stage_q;
            assign live_flat_o[g*REG_W +: REG_W] = live_q;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst)
            xray_clr_o <= 1'b0;
        else
            xray_clr_o <= wr.valid && (wr.idx == 8'h00) && wr.data[CLR_BIT];
    end

    // R5: live copy is frozen outside the retrace strobe
    assert_live_hold_R5: assert property (@(posedge clk) disable iff (rst)
        !commit_i |=> $stable(live_flat_o));

    // R5: a strobe copies the whole staging set
    assert_commit_copy_R5: assert property (@(posedge clk) disable iff (rst)
        commit_i |=> (live_flat_o == $past(stage_flat)));

    // R9: release request is a single-cycle pulse
    assert_clr_single_R9: assert property (@(posedge clk) disable iff (rst)
        xray_clr_o |=> !xray_clr_o);

endmodule

// File: rtl/defl_ctrl_regbank.sv
module defl_ctrl_regbank
    import defl_regbank_pkg::*;
#(
    parameter logic [6:0] SLAVE_ADDR  = 7'h46,
    parameter int         NUM_REGS_P  = NUM_REGS,
    parameter int         SYNC_STAGES = 2
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        scl_i,
    input  logic                        sda_i,
    output logic                        sda_oe_o,
    input  logic                        vretrace_i,
    input  logic                        hlock_i,
    input  logic                        vlock_i,
    input  logic                        xray_latched_i,
    input  logic                        hpol_i,
    input  logic                        vpol_i,
    input  logic                        vext_det_i,
    input  logic                        sep_det_i,
    output logic [NUM_REGS_P*REG_W-1:0] live_regs_o,
    output logic                        xray_clr_o
);
    localparam int STAT_W = 7;

    logic    scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic [STAT_W-1:0] stat_raw, stat_s;
    status_t stat;
    wr_req_t wr;

    i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .scl_raw(scl_i), .sda_raw(sda_i),
        .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    assign stat_raw = {hlock_i, vlock_i, xray_latched_i, hpol_i, vpol_i,
                       vext_det_i, sep_det_i};

    status_sync #(.WIDTH(STAT_W), .STAGES(SYNC_STAGES)) u_stat (
        .clk(clk), .rst(rst), .d_in(stat_raw), .d_out(stat_s)
    );

    always_comb begin
        stat        = '0;
        stat.hlock  = stat_s[6];
        stat.vlock  = stat_s[5];
        stat.xray   = stat_s[4];
        stat.hpol   = stat_s[3];
        stat.vpol   = stat_s[2];
        stat.vext   = stat_s[1];
        stat.sepdet = stat_s[0];
    end

    i2c_slave_engine #(.SLAVE_ADDR(SLAVE_ADDR), .NUM_REGS_P(NUM_REGS_P)) u_eng (
        .clk(clk), .rst(rst), .scl_s(scl_s), .sda_s(sda_s),
        .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det),
        .status_byte(byte_t'(stat)), .sda_oe(sda_oe_o), .wr(wr)
    );

    ctrl_reg_file #(.NUM_REGS_P(NUM_REGS_P)) u_regs (
        .clk(clk), .rst(rst), .wr(wr), .commit_i(vretrace_i),
        .live_flat_o(live_regs_o), .xray_clr_o(xray_clr_o)
    );

endmodule

// File: tb/defl_ctrl_regbank_tb_top.sv
module defl_ctrl_regbank_tb_top;
    localparam int H = 20;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scl_m = 1'b1, sda_m = 1'b1;
    logic vretrace = 1'b0;
    logic hlock = 0, vlock = 0, xlat = 0, hpol = 0, vpol = 0, vext = 0, sepd = 0;
    logic sda_oe;
    logic [127:0] live;
    logic xclr;
    logic sda_line;

    int n_tests = 0, n_fail = 0, clr_cnt = 0;
    bit done = 0;
    logic [7:0] exp_stage [16];
    logic [7:0] exp_live  [16];

    assign sda_line = sda_m & ~sda_oe;

    always #2 clk = ~clk;

    always @(posedge clk) if (xclr) clr_cnt <= clr_cnt + 1;

    defl_ctrl_regbank dut_i (
        .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_line), .sda_oe_o(sda_oe),
        .vretrace_i(vretrace), .hlock_i(hlock), .vlock_i(vlock),
        .xray_latched_i(xlat), .hpol_i(hpol), .vpol_i(vpol),
        .vext_det_i(vext), .sep_det_i(sepd),
        .live_regs_o(live), .xray_clr_o(xclr)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; tick(H/2);
        scl_m = 1'b1; tick(H);
        sda_m = 1'b0; tick(H);
        scl_m = 1'b0; tick(H/2);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; tick(H/2);
        scl_m = 1'b1; tick(H);
        sda_m = 1'b1; tick(H);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; tick(H/2);
            scl_m = 1'b1; tick(H);
            scl_m = 1'b0; tick(H/2);
        end
        sda_m = 1'b1; tick(H/2);
        scl_m = 1'b1; tick(H/2);
        ack = ~sda_line;
        tick(H/2);
        scl_m = 1'b0; tick(H/2);
    endtask

    task automatic recv_byte(output logic [7:0] b);
        b = '0;
        sda_m = 1'b1;
        for (int i = 0; i < 8; i++) begin
            tick(H/2);
            scl_m = 1'b1; tick(H/2);
            b = {b[6:0], sda_line};
            tick(H/2);
            scl_m = 1'b0; tick(H/2);
        end
    endtask

    task automatic master_ack(input logic nack);
        sda_m = nack; tick(H/2);
        scl_m = 1'b1; tick(H);
        scl_m = 1'b0;
        sda_m = 1'b1; tick(H/2);
    endtask

    task automatic retrace();
        vretrace = 1'b1; tick(1);
        vretrace = 1'b0;
        for (int i = 0; i < 16; i++) exp_live[i] = exp_stage[i];
    endtask

    task automatic check_live(input string tag);
        for (int i = 0; i < 16; i++)
            chk(tag, {24'd0, live[i*8 +: 8]}, {24'd0, exp_live[i]});
    endtask

    task automatic set_status(input logic [6:0] v);
        {hlock, vlock, xlat, hpol, vpol, vext, sepd} = v;
    endtask

    // R1: defaults after reset
    task automatic t_reset();
        logic [7:0] d [16] = '{8'h00, 8'h40, 8'h00, 8'h00, 8'h40, 8'hC0, 8'h40, 8'h20,
                               8'h20, 8'hA0, 8'h40, 8'hC0, 8'h00, 8'hA0, 8'hA0, 8'h20};
        for (int i = 0; i < 16; i++) begin exp_stage[i] = d[i]; exp_live[i] = d[i]; end
        check_live("R1 reset default");
        chk("R1 sda released", {31'd0, sda_oe}, 32'd0);
        retrace();
        check_live("R1 staging default");
    endtask

    // R2 R3 R4 R5: plain write then commit
    task automatic t_write_commit();
        logic a;
        bus_start();
        send_byte(8'h8C, a); chk("R2 write address ack", {31'd0, a}, 32'd1);
        send_byte(8'h05, a); chk("R3 subaddress ack", {31'd0, a}, 32'd1);
        send_byte(8'h3C, a); chk("R4 data ack", {31'd0, a}, 32'd1);
        send_byte(8'h5A, a); chk("R4 auto-increment ack", {31'd0, a}, 32'd1);
        bus_stop();
        exp_stage[5] = 8'h3C; exp_stage[6] = 8'h5A;
        tick(10);
        check_live("R5 live held before retrace");
        retrace();
        check_live("R4 R5 live after retrace");
    endtask

    // R2: foreign address ignored
    task automatic t_foreign();
        logic a;
        bus_start();
        send_byte(8'h90, a); chk("R2 foreign address nack", {31'd0, a}, 32'd0);
        send_byte(8'h05, a); chk("R2 ignored byte nack", {31'd0, a}, 32'd0);
        send_byte(8'h11, a); chk("R2 ignored data nack", {31'd0, a}, 32'd0);
        bus_stop();
        retrace();
        check_live("R2 no change after foreign write");
    endtask

    // R3: out-of-range subaddress
    task automatic t_bad_sub();
        logic a;
        bus_start();
        send_byte(8'h8C, a);
        send_byte(8'h10, a); chk("R3 subaddress 0x10 nack", {31'd0, a}, 32'd0);
        send_byte(8'h77, a); chk("R3 following data nack", {31'd0, a}, 32'd0);
        bus_stop();
        retrace();
        check_live("R3 no change after bad subaddress");
    endtask

    // R6: auto-increment stops at the last register
    task automatic t_overrun();
        logic a;
        bus_start();
        send_byte(8'h8C, a);
        send_byte(8'h0E, a);
        send_byte(8'h81, a); chk("R6 byte to 0x0E ack", {31'd0, a}, 32'd1);
        send_byte(8'h82, a); chk("R6 byte to 0x0F ack", {31'd0, a}, 32'd1);
        send_byte(8'h83, a); chk("R6 byte past 0x0F nack", {31'd0, a}, 32'd0);
        bus_stop();
        exp_stage[14] = 8'h81; exp_stage[15] = 8'h82;
        retrace();
        check_live("R6 no wrap to 0x00");
    endtask

    // R7 R8: status reads
    task automatic t_read();
        logic a;
        logic [7:0] b;
        set_status(7'b1010011);
        tick(10);
        bus_start();
        send_byte(8'h8D, a); chk("R2 read address ack", {31'd0, a}, 32'd1);
        recv_byte(b); chk("R7 status byte", {24'd0, b}, 32'hA6);
        master_ack(1'b1);
        tick(H/2);
        chk("R8 released after master nack", {31'd0, sda_oe}, 32'd0);
        bus_stop();
        set_status(7'b0111100);
        tick(10);
        bus_start();
        send_byte(8'h8D, a);
        recv_byte(b); chk("R7 second pattern", {24'd0, b}, 32'h78);
        set_status(7'b1100001);
        master_ack(1'b0);
        recv_byte(b); chk("R8 resampled after master ack", {24'd0, b}, 32'hC2);
        master_ack(1'b1);
        chk("R8 released at end", {31'd0, sda_oe}, 32'd0);
        bus_stop();
    endtask

    // R9: latch release pulse
    task automatic t_xray();
        logic a;
        int c0;
        c0 = clr_cnt;
        bus_start();
        send_byte(8'h8C, a);
        send_byte(8'h00, a);
        send_byte(8'h40, a);
        bus_stop();
        exp_stage[0] = 8'h40;
        chk("R9 one pulse when bit 6 set", clr_cnt - c0, 32'd1);
        chk("R9 pulse before retrace, live unchanged", {24'd0, live[7:0]}, {24'd0, exp_live[0]});
        c0 = clr_cnt;
        bus_start();
        send_byte(8'h8C, a);
        send_byte(8'h00, a);
        send_byte(8'h80, a);
        bus_stop();
        exp_stage[0] = 8'h80;
        chk("R9 no pulse when bit 6 clear", clr_cnt - c0, 32'd0);
        retrace();
        check_live("R9 drive enable committed");
    endtask

    // R10: repeated start and aborted write
    task automatic t_restart();
        logic a;
        logic [7:0] b;
        set_status(7'b0000010);
        bus_start();
        send_byte(8'h8C, a);
        send_byte(8'h02, a);
        send_byte(8'h33, a); chk("R10 data before repeated start", {31'd0, a}, 32'd1);
        bus_start();
        send_byte(8'h8D, a); chk("R10 read after repeated start", {31'd0, a}, 32'd1);
        recv_byte(b); chk("R10 status after repeated start", {24'd0, b}, 32'h04);
        master_ack(1'b1);
        bus_stop();
        exp_stage[2] = 8'h33;
        bus_start();
        send_byte(8'h8C, a);
        send_byte(8'h03, a);
        bus_stop();
        bus_start();
        send_byte(8'h8C, a); chk("R10 new write after stop", {31'd0, a}, 32'd1);
        send_byte(8'h09, a);
        send_byte(8'h1F, a);
        bus_stop();
        exp_stage[9] = 8'h1F;
        retrace();
        check_live("R10 registers after abort and restart");
    endtask

    initial begin
        tick(5);
        rst = 1'b0;
        tick(5);
        t_reset();
        t_write_commit();
        t_foreign();
        t_bad_sub();
        t_overrun();
        t_read();
        t_xray();
        t_restart();
        if (!done) begin
            done = 1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_tests++; n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule